// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block sends frames that software has queued in a circular ring of transmit descriptors in shared memory. Software fills a 32-byte descriptor with a buffer pointer, a frame length and a pointer to the next descriptor. It then sets the ownership bit to hand the descriptor to the hardware, and writes a poll command. The engine reads the descriptor at its current position. If the hardware owns it, the engine fetches the buffer one 32-bit word at a time and presents the bytes on a ready/valid byte stream that marks the first and last byte of each frame.

After the last byte the engine writes the descriptor's first word back with the ownership bit cleared and pulses a transmit-finished strobe. It then follows the next pointer. It keeps going until it meets a descriptor that software still owns, and there it waits for the next poll. A poll that arrives while a frame is in flight is kept and honoured once the engine is idle. The ring start address is written as two 16-bit halves, and each half-write also moves the current position to the ring start. CRC generation, line coding and collision handling belong to the MAC after this block.

Top module: `txring_engine`

## Requirements
- R1: During and right after reset, tx_valid, tx_done, mem_rd_en and mem_wr_en are all low.
- R2: A write with cfg_addr=0 sets bits 15:0 of the ring start address, and a write with cfg_addr=1 sets bits 31:16. Either write makes the ring start the current descriptor, so the first memory read after the next poll uses that exact 32-bit address.
- R3: A write with cfg_addr=2 and cfg_wdata bit 0 set is a poll command. A write to cfg_addr=2 with bit 0 clear causes no memory access.
- R4: Descriptor word 0 holds the status in bits 15:0 and the length in bits 31:16; status bit 15 set means the hardware owns the descriptor. When that bit is clear, the engine sends no byte, writes nothing and returns to idle.
- R5: For an owned descriptor, the engine streams the bytes at the buffer pointer (descriptor offset 4), lowest address first, so each memory word goes out least-significant byte first. tx_sof is high on the first byte only and tx_eof on the last byte only.
- R6: After a frame, the engine writes descriptor word 0 with bit 15 cleared and the other status bits and the length unchanged. It raises tx_done for exactly one cycle per descriptor, in the cycle after the last byte is accepted.
- R7: After releasing a descriptor, the engine continues at the address in the next pointer (descriptor offset 8), in link order rather than address order. It stops only at a host-owned descriptor, which it reads once.
- R8: A poll command that arrives while the engine is busy is kept. Once the engine stops at a host-owned descriptor, it reads that descriptor a second time.
- R9: A length above MAX_FRAME (1536) sends exactly MAX_FRAME bytes. A length of 0 sends no byte, but the descriptor is still released and tx_done still pulses.
- R10: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_sof and tx_eof hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_addr | input | 2 | Register select: 0 ring start low, 1 ring start high, 2 poll |
| cfg_wdata | input | 16 | Host write data |
| mem_rd_en | output | 1 | Memory read request; data is returned on the next cycle |
| mem_wr_en | output | 1 | Memory write of one 32-bit word |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd_en |
| tx_valid | output | 1 | A frame byte is presented |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | The MAC accepts the byte |
| tx_done | output | 1 | One-cycle transmit-finished strobe |

## Verification
The bench sweeps frame lengths around the 4-byte word boundary (1 to 9 bytes), plus the 60- and 64-byte padded sizes, 0, and a length above the limit. It uses a chain whose links skip around in memory and a back-pressure pattern that stalls the byte stream. An engine with the wrong lane order or an off-by-one at a word edge would garble or drop bytes. A missing clamp would stream 2000 bytes, and an engine that skips zero-length descriptors would never release them or pulse tx_done. Two further checks cover the ownership handling: a lost busy-time poll shows up as a single read of the terminating descriptor instead of two, and a write-back that touches the wrong bits shows up as a changed status word or length.

// File: rtl/txr_pkg.sv
// Shared constants and types for the transmit descriptor ring engine.
// Assumes a 32-bit little-endian memory word and 32-bit byte addresses.
package txr_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LEN_W      = 16;
    localparam int OWN_BIT    = 15;
    localparam logic [ADDR_W-1:0] OFS_BUF  = 32'd4;
    localparam logic [ADDR_W-1:0] OFS_NEXT = 32'd8;
    localparam logic [1:0] SEL_BASE_LO = 2'd0;
    localparam logic [1:0] SEL_BASE_HI = 2'd1;
    localparam logic [1:0] SEL_POLL    = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR_RQ, ST_HDR_RS, ST_PTR_RQ, ST_PTR_RS,
        ST_NXT_RQ, ST_NXT_RS, ST_DAT_RQ, ST_DAT_RS, ST_SEND, ST_WBACK
    } eng_state_t;
endpackage

// File: rtl/txr_host_regs.sv
// Host-visible registers: the ring start address (two 16-bit halves) and a
// sticky poll request. Assumes the host changes the ring start only while
// the engine is idle.
module txr_host_regs
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              poll_take,
    output logic [ADDR_W-1:0] ring_base,
    output logic              base_load,
    output logic              poll_pend
);
    logic poll_hit;
    assign poll_hit = cfg_wr && (cfg_addr == SEL_POLL) && cfg_wdata[0];

    // Capture the address halves, flag a reload, and keep poll requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            base_load <= 1'b0;
            poll_pend <= 1'b0;
        end else begin
            base_load <= cfg_wr && (cfg_addr == SEL_BASE_LO || cfg_addr == SEL_BASE_HI);
            if (cfg_wr && cfg_addr == SEL_BASE_LO) ring_base[15:0]  <= cfg_wdata;
            if (cfg_wr && cfg_addr == SEL_BASE_HI) ring_base[31:16] <= cfg_wdata;
            poll_pend <= (poll_pend && !poll_take) || poll_hit;
        end
    end

    // A poll command is never lost, even when it arrives during a take.
    assert_poll_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_hit |=> poll_pend);
endmodule

// File: rtl/txr_byte_pick.sv
// Selects one byte lane of a memory word; lane 0 is the lowest address.
// Assumes LANES is a power of two.
module txr_byte_pick #(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word_i,
    input  logic [SEL_W-1:0]   lane_i,
    output logic [7:0]         byte_o
);
    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/txring_engine.sv
// Transmit descriptor ring engine. Walks a linked ring of 32-byte
// descriptors, streams each hardware-owned frame as bytes, then releases
// the descriptor and follows its next pointer. Assumes word-aligned buffer
// and descriptor pointers and memory read data one cycle after the request.
module txring_engine
    import txr_pkg::*;
#(
    parameter int MAX_FRAME = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              tx_ready,
    output logic              tx_done
);
    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_FRAME);

    eng_state_t        st;
    logic [ADDR_W-1:0] cur_desc, buf_ptr, nxt_ptr, ring_base;
    logic [WORD_W-1:0] hdr_q, data_q;
    logic [LEN_W-1:0]  len_q, cnt_q, raw_len;
    logic              base_load, poll_pend, poll_take, last_byte;

    txr_host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .poll_take(poll_take), .ring_base(ring_base),
        .base_load(base_load), .poll_pend(poll_pend)
    );

    txr_byte_pick #(.LANES(WORD_BYTES)) u_pick (
        .word_i(data_q), .lane_i(cnt_q[LANE_W-1:0]), .byte_o(tx_data)
    );

    assign raw_len   = mem_rdata[31:16];
    assign last_byte = (cnt_q == len_q - 1'b1);
    assign poll_take = (st == ST_IDLE) && poll_pend;

    // Drive the memory port and stream flags from the current state.
    always_comb begin
        mem_rd_en = (st == ST_HDR_RQ) || (st == ST_PTR_RQ) ||
                    (st == ST_NXT_RQ) || (st == ST_DAT_RQ);
        mem_wr_en = (st == ST_WBACK);
        case (st)
            ST_PTR_RQ: mem_addr = cur_desc + OFS_BUF;
            ST_NXT_RQ: mem_addr = cur_desc + OFS_NEXT;
            ST_DAT_RQ: mem_addr = buf_ptr + ADDR_W'(cnt_q);
            default:   mem_addr = cur_desc;
        endcase
        mem_wdata = hdr_q;
        mem_wdata[OWN_BIT] = 1'b0;
        tx_valid = (st == ST_SEND);
        tx_sof   = tx_valid && (cnt_q == '0);
        tx_eof   = tx_valid && last_byte;
        tx_done  = (st == ST_WBACK);
    end

    // Sequence descriptor reads, byte streaming and the release write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_desc <= '0;
            buf_ptr  <= '0;
            nxt_ptr  <= '0;
            hdr_q    <= '0;
            data_q   <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
        end else begin
            case (st)
                ST_IDLE:   if (poll_pend) st <= ST_HDR_RQ;
                ST_HDR_RQ: st <= ST_HDR_RS;
                ST_HDR_RS: begin
                    hdr_q <= mem_rdata;
                    len_q <= (raw_len > LEN_CAP) ? LEN_CAP : raw_len;
                    st    <= mem_rdata[OWN_BIT] ? ST_PTR_RQ : ST_IDLE;
                end
                ST_PTR_RQ: st <= ST_PTR_RS;
                ST_PTR_RS: begin
                    buf_ptr <= mem_rdata;
                    st      <= ST_NXT_RQ;
                end
                ST_NXT_RQ: st <= ST_NXT_RS;
                ST_NXT_RS: begin
                    nxt_ptr <= mem_rdata;
                    cnt_q   <= '0;
                    st      <= (len_q == '0) ? ST_WBACK : ST_DAT_RQ;
                end
                ST_DAT_RQ: st <= ST_DAT_RS;
                ST_DAT_RS: begin
                    data_q <= mem_rdata;
                    st     <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_byte)
                        st <= ST_WBACK;
                    else if (&cnt_q[LANE_W-1:0])
                        st <= ST_DAT_RQ;
                end
                ST_WBACK: begin
                    cur_desc <= nxt_ptr;
                    st       <= ST_HDR_RQ;
                end
                default: st <= ST_IDLE;
            endcase
            if (base_load) cur_desc <= ring_base;
        end
    end

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                     $stable(tx_sof) && $stable(tx_eof)));

    assert_port_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_release_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eof) |=> (mem_wr_en && tx_done && !tx_valid));

    assert_hostowned_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR_RS && !mem_rdata[OWN_BIT]) |=> (!tx_valid && !mem_wr_en));

    assert_sof_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_sof && !tx_eof) |=> !tx_sof);

    assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (cnt_q < LEN_CAP));
endmodule

// File: tb/test_txring_engine.sv
module test_txring_engine;
    localparam int MAXF = 1536;
    localparam logic [31:0] HI  = 32'h0005_0000;
    localparam logic [31:0] DA  = HI | 32'h100;
    localparam logic [31:0] DC  = HI | 32'h120;
    localparam logic [31:0] DB  = HI | 32'h140;
    localparam logic [31:0] DT  = HI | 32'h160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_sof, tx_eof, tx_done;
    logic [7:0] tx_data;
    logic tx_ready = 1'b1;

    always #4 clk = ~clk;

    txring_engine #(.MAX_FRAME(MAXF)) i_txring_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready), .tx_done(tx_done)
    );

    // memory model: one-cycle read latency, 16 KiB aliased over the address
    logic [31:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[13:2]];
        if (mem_wr_en) mem[mem_addr[13:2]] = mem_wdata;
    end

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int stall_mode = 0;

    // capture state
    logic [7:0] cap_b [0:4095];
    bit cap_s [0:4095];
    bit cap_e [0:4095];
    int cap_n = 0, rd_total = 0, wr_total = 0, done_cnt = 0, done_dbl = 0;
    int term_reads = 0, hold_err = 0;
    bit first_seen = 0, prev_stall = 0, prev_done = 0;
    logic [31:0] first_rd = '0;
    logic [7:0] prev_data = '0;
    logic prev_sof = 0, prev_eof = 0;

    // set ready for the coming edge, then record what that edge will accept
    always @(negedge clk) begin
        cyc++;
        tx_ready = (stall_mode == 0) || ((cyc % stall_mode) != 0);
        if (prev_stall && !(tx_valid && tx_data == prev_data &&
                            tx_sof == prev_sof && tx_eof == prev_eof))
            hold_err++;
        prev_stall = tx_valid && !tx_ready;
        prev_data = tx_data; prev_sof = tx_sof; prev_eof = tx_eof;
        if (tx_valid && tx_ready && cap_n < 4096) begin
            cap_b[cap_n] = tx_data; cap_s[cap_n] = tx_sof; cap_e[cap_n] = tx_eof;
            cap_n++;
        end
        if (mem_rd_en) begin
            rd_total++;
            if (!first_seen) begin first_seen = 1; first_rd = mem_addr; end
            if (mem_addr == DT) term_reads++;
        end
        if (mem_wr_en) wr_total++;
        if (tx_done) begin
            done_cnt++;
            if (prev_done) done_dbl++;
        end
        prev_done = tx_done;
    end

    function automatic logic [7:0] pat(input int a);
        int b = a & 16'h3FFF;
        return 8'(((b & 255) + 3 * (b >> 8) + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic clear_mon();
        cap_n = 0; rd_total = 0; wr_total = 0; done_cnt = 0; done_dbl = 0;
        term_reads = 0; hold_err = 0; first_seen = 0;
    endtask

    task automatic put_desc(input logic [31:0] d, input bit own, input int len,
                            input int st_lo, input logic [31:0] bufp,
                            input logic [31:0] nxt);
        int w = int'(d[13:2]);
        mem[w]   = {16'(len), own, 15'(st_lo)};
        mem[w+1] = bufp;
        mem[w+2] = nxt;
    endtask

    task automatic set_base(input logic [31:0] b);
        cfg(2'd0, b[15:0]);
        cfg(2'd1, b[31:16]);
        @(negedge clk);
    endtask

    // three linked frames A -> B -> C -> T (T host-owned), link order not address order
    task automatic run_round(input int l0, input int l1, input int l2,
                             input int stall, input bit busy_poll);
        int lens [3];
        logic [31:0] ds [3];
        logic [31:0] bs [3];
        int k, eff, exp_n, bad;
        lens[0] = l0; lens[1] = l1; lens[2] = l2;
        ds[0] = DA; ds[1] = DB; ds[2] = DC;
        bs[0] = HI | 32'h1000; bs[1] = HI | 32'h1800; bs[2] = HI | 32'h2000;
        put_desc(DA, 1, l0, 16'h21, bs[0], DB);
        put_desc(DB, 1, l1, 16'h0A5, bs[1], DC);
        put_desc(DC, 1, l2, 16'h7FF, bs[2], DT);
        put_desc(DT, 0, 12, 16'h3, bs[0], DA);
        stall_mode = stall;
        set_base(DA);
        clear_mon();
        cfg(2'd2, 16'h0001);
        if (busy_poll) begin
            while (cap_n < 2) @(negedge clk);
            cfg(2'd2, 16'h0001);
        end
        while (done_cnt < 3) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(first_rd == DA, "R2", "first header address", first_rd, DA);
        exp_n = 0;
        for (int f = 0; f < 3; f++) exp_n += (lens[f] > MAXF) ? MAXF : lens[f];
        chk(cap_n == exp_n, "R5", "byte count", cap_n, exp_n);
        bad = 0; k = 0;
        for (int f = 0; f < 3; f++) begin
            eff = (lens[f] > MAXF) ? MAXF : lens[f];
            for (int i = 0; i < eff; i++) begin
                if (k < cap_n && (cap_b[k] != pat(int'(bs[f]) + i) ||
                    cap_s[k] != (i == 0) || cap_e[k] != (i == eff - 1)))
                    bad++;
                k++;
            end
        end
        chk(bad == 0, "R5", "bytes/sof/eof mismatches (R7 link order)", bad, 0);
        chk(mem[DA[13:2]] == {16'(l0), 16'h0021}, "R6", "release word A",
            mem[DA[13:2]], {16'(l0), 16'h0021});
        chk(mem[DB[13:2]] == {16'(l1), 16'h00A5}, "R6", "release word B",
            mem[DB[13:2]], {16'(l1), 16'h00A5});
        chk(mem[DC[13:2]] == {16'(l2), 16'h07FF}, "R6", "release word C",
            mem[DC[13:2]], {16'(l2), 16'h07FF});
        chk(done_cnt == 3 && done_dbl == 0, "R6", "done pulses (x10 + double)",
            done_cnt * 10 + done_dbl, 30);
        chk(wr_total == 3, "R6", "write count", wr_total, 3);
        chk(term_reads == (busy_poll ? 2 : 1), busy_poll ? "R8" : "R7",
            "reads of host-owned terminator", term_reads, busy_poll ? 2 : 1);
        chk(hold_err == 0, "R10", "stream changed while stalled", hold_err, 0);
    endtask

    initial begin
        for (int w = 0; w < 4096; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        repeat (3) @(negedge clk);
        chk(!tx_valid && !tx_done && !mem_rd_en && !mem_wr_en, "R1",
            "outputs in reset", {tx_valid, tx_done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_valid && !tx_done && !mem_rd_en && !mem_wr_en, "R1",
            "outputs after reset", {tx_valid, tx_done, mem_rd_en, mem_wr_en}, 0);

        // R4: ring start at a host-owned descriptor
        put_desc(DT, 0, 20, 16'h3, HI | 32'h1000, DA);
        set_base(DT);
        clear_mon();
        cfg(2'd2, 16'h0001);
        repeat (30) @(negedge clk);
        chk(first_rd == DT, "R2", "first read at ring start", first_rd, DT);
        chk(cap_n == 0, "R4", "bytes from host-owned", cap_n, 0);
        chk(wr_total == 0 && done_cnt == 0, "R4", "writes/done on host-owned",
            wr_total + done_cnt, 0);
        chk(rd_total == 1, "R4", "reads on host-owned", rd_total, 1);

        // R3: poll register write with bit 0 clear does nothing
        put_desc(DA, 1, 8, 16'h21, HI | 32'h1000, DT);
        set_base(DA);
        clear_mon();
        cfg(2'd2, 16'h0002);
        repeat (40) @(negedge clk);
        chk(rd_total == 0 && cap_n == 0, "R3", "activity after non-poll write",
            rd_total + cap_n, 0);

        // sweep lengths around the word boundary
        for (int a = 1; a <= 9; a++)
            run_round(a, (a % 4) + 1, 10 - a, a % 3 == 0 ? 0 : 3, 0);
        run_round(60, 64, 61, 5, 0);
        run_round(0, 5, 0, 0, 0);        // R9 zero length
        run_round(2000, 1, 3, 4, 0);     // R9 clamp
        run_round(9, 9, 9, 3, 1);        // R8 poll while busy

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog: actual=%0d cycles expected=completion", 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule